// File: doc/BRIEF.md
# Privileged 64-bit Time Base Counter

This block keeps a 64-bit unsigned count that advances by one on each cycle in which an external tick enable is high. The tick comes from outside, and its spacing may change over time. Software sees the count as two 32-bit halves through a special-register access port. Each access presents a register number, a read/write flag and a privilege bit.

Reads use one pair of register numbers and are open to any privilege level. Writes use a different pair of numbers and take effect only at supervisor level. A write replaces just the half it names. Any write the block refuses leaves the count alone and raises a fault pulse for one cycle: either a user-level write to a write number, or a write at any level to a read number. Register numbers that belong to neither pair are left for other units, so the block ignores them.

Top module: `tbase_unit`

## Requirements
- R1: Reset (rst_n low) clears both halves to zero and holds fault_o low.
- R2: On a clock edge with tick_i high and no accepted write, the 64-bit count increases by exactly one. Without tick_i the count holds.
- R3: When the lower half goes from 0xFFFFFFFF to 0 on a tick, the upper half increases by one. A count of all ones wraps to all zeros.
- R4: A read (acc_valid_i=1, acc_write_i=0) at RD_LO (default 268) returns the lower half on rdata_o in the same cycle. At RD_HI (default 269) it returns the upper half. This holds at either privilege level, and reads never change the count or raise fault_o.
- R5: A supervisor write (acc_sup_i=1) to WR_LO (default 284) replaces only the lower half with wdata_i. A supervisor write to WR_HI (default 285) replaces only the upper half. The new value is visible after the next clock edge.
- R6: A tick in the same cycle as an accepted write is dropped. The half that is not written keeps its value, and nothing is added to the count.
- R7: A user-level write (acc_sup_i=0) to WR_LO or WR_HI leaves the count unchanged apart from a normal tick. It sets fault_o high for the cycle after the access.
- R8: A write at any privilege level to RD_LO or RD_HI leaves the count unchanged apart from a normal tick. It sets fault_o high for the cycle after the access.
- R9: At any other register number, a read returns zero, a write is ignored, and fault_o stays low.
- R10: fault_o is a single-cycle pulse. It is low in any cycle that does not follow a refused write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-advance enable |
| acc_valid_i | input | 1 | Register access present this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_sup_i | input | 1 | 1 = supervisor, 0 = user |
| acc_num_i | input | NUM_W | Special-register number |
| wdata_i | input | HALF_W | Write data |
| rdata_o | output | HALF_W | Read data (combinational) |
| fault_o | output | 1 | Refused-write pulse |

## Verification
The bench drives the lower half to all ones and ticks, so a design that dropped the carry would leave the upper half stuck at zero. It then forces both halves to all ones and ticks again, so a design that saturated would not wrap to zero. A write paired with a tick exposes a design that still counts during a write, because the unwritten half or the new value would come out one too high. User writes and writes to read numbers must both pulse the fault without changing the count. If the fault latched, it would stay high through the idle cycle that follows.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

   // Decoded view of one special-register access
   typedef struct packed {
      logic rd_lo;     // read of the lower half
      logic rd_hi;     // read of the upper half
      logic wr_lo;     // accepted write of the lower half
      logic wr_hi;     // accepted write of the upper half
      logic refused;   // write that must be rejected
   } tb_dec_t;

endpackage

// File: rtl/tbase_decode.sv
module tbase_decode
   import tbase_pkg::*;
#(
   parameter int          NUM_W = 10,
   parameter logic [NUM_W-1:0] RD_LO = 268,
   parameter logic [NUM_W-1:0] RD_HI = 269,
   parameter logic [NUM_W-1:0] WR_LO = 284,
   parameter logic [NUM_W-1:0] WR_HI = 285
) (
   input  logic             valid,
   input  logic             write,
   input  logic             sup,
   input  logic [NUM_W-1:0] num,
   output tb_dec_t          dec
);
   logic hit_rl, hit_rh, hit_wl, hit_wh;

   always_comb begin
      hit_rl = (num == RD_LO);
      hit_rh = (num == RD_HI);
      hit_wl = (num == WR_LO);
      hit_wh = (num == WR_HI);
      dec.rd_lo   = valid && !write && hit_rl;
      dec.rd_hi   = valid && !write && hit_rh;
      dec.wr_lo   = valid &&  write && sup && hit_wl;
      dec.wr_hi   = valid &&  write && sup && hit_wh;
      dec.refused = valid &&  write &&
                    ((!sup && (hit_wl || hit_wh)) || hit_rl || hit_rh);
   end
endmodule

// File: rtl/tbase_half.sv
module tbase_half #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         inc,
   output logic [W-1:0] q,
   output logic         full
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= load_val;
      else if (inc)   q <= q + W'(1);
   end

   assign full = &q;
endmodule

// File: rtl/tbase_unit.sv
module tbase_unit
   import tbase_pkg::*;
#(
   parameter int          HALF_W = 32,
   parameter int          NUM_W  = 10,
   parameter logic [NUM_W-1:0] RD_LO = 268,
   parameter logic [NUM_W-1:0] RD_HI = 269,
   parameter logic [NUM_W-1:0] WR_LO = 284,
   parameter logic [NUM_W-1:0] WR_HI = 285
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              acc_valid_i,
   input  logic              acc_write_i,
   input  logic              acc_sup_i,
   input  logic [NUM_W-1:0]  acc_num_i,
   input  logic [HALF_W-1:0] wdata_i,
   output logic [HALF_W-1:0] rdata_o,
   output logic              fault_o
);
   localparam int NHALF = 2;
   localparam int CNT_W = NHALF * HALF_W;

   initial begin
      assert (HALF_W >= 1 && NUM_W >= 1)
         else $error("tbase_unit: widths must be positive");
      assert (RD_LO != RD_HI && RD_LO != WR_LO && RD_LO != WR_HI &&
              RD_HI != WR_LO && RD_HI != WR_HI && WR_LO != WR_HI)
         else $error("tbase_unit: register numbers must be distinct");
   end

   tb_dec_t            dec;
   logic [NHALF-1:0]   load;
   logic [NHALF-1:0]   inc;
   logic [NHALF-1:0]   full;
   logic [HALF_W-1:0]  q [NHALF];
   logic [CNT_W-1:0]   cnt;
   logic               tick_ok;

   tbase_decode #(
      .NUM_W(NUM_W), .RD_LO(RD_LO), .RD_HI(RD_HI),
      .WR_LO(WR_LO), .WR_HI(WR_HI)
   ) u_dec (
      .valid (acc_valid_i),
      .write (acc_write_i),
      .sup   (acc_sup_i),
      .num   (acc_num_i),
      .dec   (dec)
   );

   assign load    = {dec.wr_hi, dec.wr_lo};
   assign tick_ok = tick_i && !(|load);

   for (genvar h = 0; h < NHALF; h++) begin : g_half
      if (h == 0) begin : g_first
         assign inc[h] = tick_ok;
      end else begin : g_chain
         assign inc[h] = inc[h-1] && full[h-1];
      end

      tbase_half #(.W(HALF_W)) u_half (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load[h]),
         .load_val (wdata_i),
         .inc      (inc[h]),
         .q        (q[h]),
         .full     (full[h])
      );

      assign cnt[h*HALF_W +: HALF_W] = q[h];
   end

   always_comb begin
      if (dec.rd_lo)      rdata_o = q[0];
      else if (dec.rd_hi) rdata_o = q[1];
      else                rdata_o = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) fault_o <= 1'b0;
      else        fault_o <= dec.refused;
   end
endmodule

// File: rtl/tbase_chk.sv
module tbase_chk #(
   parameter int          HALF_W = 32,
   parameter int          NUM_W  = 10,
   parameter logic [NUM_W-1:0] RD_LO = 268,
   parameter logic [NUM_W-1:0] RD_HI = 269,
   parameter logic [NUM_W-1:0] WR_LO = 284,
   parameter logic [NUM_W-1:0] WR_HI = 285
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick_i,
   input logic                acc_valid_i,
   input logic                acc_write_i,
   input logic                acc_sup_i,
   input logic [NUM_W-1:0]    acc_num_i,
   input logic [HALF_W-1:0]   wdata_i,
   input logic                fault_o,
   input logic [2*HALF_W-1:0] cnt
);
   localparam int CNT_W = 2 * HALF_W;

   logic wr_num, rd_num, wr_ok, wr_bad, rd_any;
   assign wr_num = (acc_num_i == WR_LO) || (acc_num_i == WR_HI);
   assign rd_num = (acc_num_i == RD_LO) || (acc_num_i == RD_HI);
   assign wr_ok  = acc_valid_i && acc_write_i && acc_sup_i && wr_num;
   assign wr_bad = acc_valid_i && acc_write_i && ((!acc_sup_i && wr_num) || rd_num);
   assign rd_any = acc_valid_i && !acc_write_i;

   // R2 / R3: without an accepted write the count moves by the tick only
   assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ok |=> cnt == $past(cnt) + CNT_W'($past(tick_i)));

   // R5 / R6: lower-half write keeps the upper half, drops the tick
   assert_write_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && acc_num_i == WR_LO) |=>
      (cnt[HALF_W-1:0] == $past(wdata_i)) &&
      (cnt[CNT_W-1:HALF_W] == $past(cnt[CNT_W-1:HALF_W])));

   // R6: upper-half write keeps the lower half even with a tick
   assert_write_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && acc_num_i == WR_HI) |=>
      (cnt[CNT_W-1:HALF_W] == $past(wdata_i)) &&
      (cnt[HALF_W-1:0] == $past(cnt[HALF_W-1:0])));

   // R7: user write to a write number faults
   assert_user_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && acc_write_i && !acc_sup_i && wr_num) |=> fault_o);

   // R8: write to a read number faults
   assert_ro_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && acc_write_i && rd_num) |=> fault_o);

   // R4: reads never fault
   assert_read_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_any |=> !fault_o);

   // R10: fault only after a refused write
   assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_bad |=> !fault_o);
endmodule

bind tbase_unit tbase_chk #(
   .HALF_W(HALF_W), .NUM_W(NUM_W), .RD_LO(RD_LO), .RD_HI(RD_HI),
   .WR_LO(WR_LO), .WR_HI(WR_HI)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_i      (tick_i),
   .acc_valid_i (acc_valid_i),
   .acc_write_i (acc_write_i),
   .acc_sup_i   (acc_sup_i),
   .acc_num_i   (acc_num_i),
   .wdata_i     (wdata_i),
   .fault_o     (fault_o),
   .cnt         (cnt)
);

// File: tb/tbase_unit_bench.sv
module tbase_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [9:0] NRL = 10'd268;
   localparam logic [9:0] NRH = 10'd269;
   localparam logic [9:0] NWL = 10'd284;
   localparam logic [9:0] NWH = 10'd285;
   localparam logic [9:0] NOTHER = 10'd300;

   typedef struct packed {
      logic        tick;
      logic        valid;
      logic        write;
      logic        sup;
      logic [9:0]  num;
      logic [31:0] wdata;
      logic [31:0] exp_lo;
      logic [31:0] exp_hi;
      logic        exp_f;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,1'b0,1'b0,10'd0,  32'h0,        32'h1,        32'h0,        1'b0}, // R2
      '{1'b1,1'b0,1'b0,1'b0,10'd0,  32'h0,        32'h2,        32'h0,        1'b0}, // R2
      '{1'b0,1'b0,1'b0,1'b0,10'd0,  32'h0,        32'h2,        32'h0,        1'b0}, // R2 hold
      '{1'b0,1'b1,1'b1,1'b1,NWL,    32'hFFFFFFFE, 32'hFFFFFFFE, 32'h0,        1'b0}, // R5
      '{1'b1,1'b0,1'b0,1'b0,10'd0,  32'h0,        32'hFFFFFFFF, 32'h0,        1'b0}, // R2
      '{1'b1,1'b0,1'b0,1'b0,10'd0,  32'h0,        32'h0,        32'h1,        1'b0}, // R3 carry
      '{1'b0,1'b1,1'b1,1'b0,NWL,    32'h5,        32'h0,        32'h1,        1'b1}, // R7
      '{1'b0,1'b1,1'b1,1'b1,NRL,    32'h7,        32'h0,        32'h1,        1'b1}, // R8
      '{1'b1,1'b1,1'b1,1'b1,NWH,    32'hFFFFFFFF, 32'h0,        32'hFFFFFFFF, 1'b0}, // R6
      '{1'b0,1'b1,1'b1,1'b1,NWL,    32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0}, // R5
      '{1'b1,1'b0,1'b0,1'b0,10'd0,  32'h0,        32'h0,        32'h0,        1'b0}, // R3 wrap
      '{1'b1,1'b1,1'b1,1'b1,NOTHER, 32'h9,        32'h1,        32'h0,        1'b0}, // R9
      '{1'b1,1'b1,1'b0,1'b0,NRL,    32'h0,        32'h2,        32'h0,        1'b0}, // R4
      '{1'b1,1'b1,1'b1,1'b0,NWH,    32'h3,        32'h3,        32'h0,        1'b1}, // R7 tick still counts
      '{1'b0,1'b1,1'b1,1'b0,NRH,    32'h4,        32'h3,        32'h0,        1'b1}  // R8
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        acc_valid_i = 1'b0;
   logic        acc_write_i = 1'b0;
   logic        acc_sup_i = 1'b0;
   logic [9:0]  acc_num_i = '0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        fault_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tbase_unit u_tbase_unit (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
      .acc_sup_i(acc_sup_i), .acc_num_i(acc_num_i),
      .wdata_i(wdata_i), .rdata_o(rdata_o), .fault_o(fault_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      tick_i = 1'b0; acc_valid_i = 1'b0; acc_write_i = 1'b0;
      acc_sup_i = 1'b0; acc_num_i = '0; wdata_i = '0;
   endtask

   // combinational read through the port at user level
   task automatic read_half(input logic [9:0] num, output logic [31:0] val);
      tick_i = 1'b0; acc_valid_i = 1'b1; acc_write_i = 1'b0;
      acc_sup_i = 1'b0; acc_num_i = num;
      #1;
      val = rdata_o;
      acc_valid_i = 1'b0;
   endtask

   initial begin
      logic [31:0] v;
      idle_inputs();
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 fault in reset", {31'b0, fault_o}, 32'h0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      read_half(NRL, v); chk("R1 lower after reset", v, 32'h0);
      read_half(NRH, v); chk("R1 upper after reset", v, 32'h0);
      chk("R1 fault after reset", {31'b0, fault_o}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         tick_i = VECS[i].tick; acc_valid_i = VECS[i].valid;
         acc_write_i = VECS[i].write; acc_sup_i = VECS[i].sup;
         acc_num_i = VECS[i].num; wdata_i = VECS[i].wdata;
         @(posedge clk); #1;
         idle_inputs();
         chk($sformatf("vector %0d fault (R7/R8/R10)", i), {31'b0, fault_o}, {31'b0, VECS[i].exp_f});
         read_half(NRL, v); chk($sformatf("vector %0d lower (R2-R6)", i), v, VECS[i].exp_lo);
         read_half(NRH, v); chk($sformatf("vector %0d upper (R2-R6)", i), v, VECS[i].exp_hi);
      end

      // R10: fault clears after an idle cycle
      @(posedge clk); #1;
      chk("R10 fault single pulse", {31'b0, fault_o}, 32'h0);

      // R9: read of an unrelated number returns zero
      read_half(NOTHER, v); chk("R9 unknown read", v, 32'h0);
      read_half(NWL, v);    chk("R9 read of write number", v, 32'h0);

      // R4: supervisor read also works
      acc_valid_i = 1'b1; acc_sup_i = 1'b1; acc_num_i = NRL; #1;
      chk("R4 supervisor read", rdata_o, 32'h3);
      idle_inputs();

      // R1: reset mid-run clears a nonzero count
      tick_i = 1'b1; rst_n = 1'b0;
      @(posedge clk); #1;
      chk("R1 fault during reset", {31'b0, fault_o}, 32'h0);
      tick_i = 1'b0; rst_n = 1'b1;
      read_half(NRL, v); chk("R1 lower cleared", v, 32'h0);
      read_half(NRH, v); chk("R1 upper cleared", v, 32'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule